// File: doc/BRIEF.md
# Addressable Variable-Tap Shift Register

This block is a serial delay line built from a fixed chain of sixteen one-bit stages. On every rising clock edge a new bit enters the first stage and all older bits move one stage further along. A 4-bit tap select picks which stage is shown on the single output bit. The delay from input to output is therefore anywhere from one to sixteen clocks, and no stored data moves when that delay changes.

The select can be tied to a constant to get a fixed-length delay. It can also be changed on any cycle to get a dynamic length. The output is read through a combinational multiplexer tree, so it follows a change of select at once, with no clock edge needed. A parameter gives the stage contents at power-up. A synchronous active-high reset loads those same contents again.

Top module: `vtap_shift_reg`

## Requirements
- R1: Storage is always 16 stages, numbered 0 to 15. The select `tap_sel` (unsigned, 4 bits) only chooses the stage that is read. The resulting delay length is `tap_sel` + 1: select 0 gives 1 clock and select 15 gives 16 clocks.
- R2: On each rising edge with `rst` low, stage 0 takes `din` and stage k+1 takes the old value of stage k. The old value of stage 15 is lost.
- R3: `dout` equals the current contents of stage `tap_sel`. It changes as soon as `tap_sel` changes, without a clock edge.
- R4: At power-up, stage k holds bit k of parameter `INIT_VAL`. The most significant bit of `INIT_VAL` is stage 15 and the least significant bit is stage 0.
- R5: When `INIT_VAL` is not overridden it is 16'h0000, so every stage starts at 0.
- R6: On a rising edge with `rst` high, all stages load `INIT_VAL` and `din` is ignored.
- R7: Changing `tap_sel` on every cycle leaves the stored bits untouched. The output always matches the model chain at the newly selected stage.
- R8: With `tap_sel` held at s, a bit driven on `din` before an edge first appears on `dout` after s+1 rising edges. Right after an edge, `dout` shows what stage s-1 held before that edge, or what `din` was when s is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; shifting happens on the rising edge |
| rst | input | 1 | Synchronous active-high reload of `INIT_VAL` |
| din | input | 1 | Serial data written into stage 0 |
| tap_sel | input | 4 | Index of the stage driven onto `dout` |
| dout | output | 1 | Contents of the selected stage, combinational |

## Verification
The bench sweeps every select value within a single cycle, before any clock edge. A design that registered the output, or that decoded select bits in the wrong order, would show a stale or mirrored stage there. Power-up contents are checked on an instance with an asymmetric `INIT_VAL` and on one with the default value, which exposes a reversed bit-to-stage mapping. Runs with a select that jumps randomly every cycle compare against a queue model. They catch a design that resizes or moves the chain when the select changes. Latency probes at select 0, 5 and 15 catch an off-by-one delay, and a reset asserted while `din` is high catches a reload that lets data leak in.

// File: rtl/vtap_pkg.sv
package vtap_pkg;

    // Chain depth used when the top is not overridden.
    localparam int DFLT_DEPTH = 16;

    // Delay length, in clocks, that a given tap index produces.
    function automatic int tap_length(input int tap);
        return tap + 1;
    endfunction

    // Level of a node in a heap-ordered binary tree (root = level 0).
    function automatic int heap_level(input int node);
        return $clog2(node + 2) - 1;
    endfunction

    // Number of internal (mux) nodes for a tree with the given leaf count.
    function automatic int mux_nodes(input int leaves);
        return leaves - 1;
    endfunction

endpackage

// File: rtl/vtap_chain.sv
module vtap_chain #(
    parameter int               DEPTH    = vtap_pkg::DFLT_DEPTH,
    parameter logic [DEPTH-1:0] INIT_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] stages
);

    // Power-up contents come from the declaration initialiser.
    logic [DEPTH-1:0] stages_q = INIT_VAL;

    always_ff @(posedge clk) begin
        if (rst) begin
            stages_q <= INIT_VAL;
        end else begin
            stages_q <= {stages_q[DEPTH-2:0], din};
        end
    end

    assign stages = stages_q;

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stages_q[0] == $past(din)); // R2

    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stages_q[DEPTH-1:1] == $past(stages_q[DEPTH-2:0])); // R2

    AST_RESET_RELOAD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> stages_q == INIT_VAL); // R6

endmodule

// File: rtl/vtap_select_tree.sv
module vtap_select_tree #(
    parameter int DEPTH = vtap_pkg::DFLT_DEPTH,
    localparam int SEL_W = $clog2(DEPTH),
    localparam int NODES = 2 * DEPTH - 1
) (
    input  logic [DEPTH-1:0] leaves,
    input  logic [SEL_W-1:0] sel,
    output logic             picked
);

    // Heap-ordered tree: nodes 0..DEPTH-2 are 2:1 muxes, DEPTH-1.. are leaves.
    // The root decodes the select MSB, the deepest level the LSB.
    logic [NODES-1:0] node;

    for (genvar i = 0; i < DEPTH; i++) begin : g_leaf
        assign node[DEPTH-1+i] = leaves[i];
    end

    for (genvar n = 0; n < vtap_pkg::mux_nodes(DEPTH); n++) begin : g_mux
        localparam int LVL = vtap_pkg::heap_level(n);
        localparam int BIT = SEL_W - 1 - LVL;
        assign node[n] = sel[BIT] ? node[2*n+2] : node[2*n+1];
    end

    assign picked = node[0];

endmodule

// File: rtl/vtap_shift_reg.sv
module vtap_shift_reg #(
    parameter int               DEPTH    = vtap_pkg::DFLT_DEPTH,
    parameter logic [DEPTH-1:0] INIT_VAL = '0,
    localparam int              SEL_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             dout
);

    logic [DEPTH-1:0] stages;

    vtap_chain #(
        .DEPTH    (DEPTH),
        .INIT_VAL (INIT_VAL)
    ) u_chain (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .stages (stages)
    );

    vtap_select_tree #(
        .DEPTH (DEPTH)
    ) u_tree (
        .leaves (stages),
        .sel    (tap_sel),
        .picked (dout)
    );

    // Snapshot of the chain one edge back, used only to check latency.
    logic [DEPTH-1:0] stages_prev;
    always_ff @(posedge clk) begin
        stages_prev <= stages;
    end

    AST_TAP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && tap_sel != '0) |-> dout == stages_prev[SEL_W'(tap_sel - 1'b1)]); // R8

    AST_TAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && tap_sel == '0) |-> dout == $past(din)); // R8

    AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ($stable(tap_sel) && !$past(rst) && tap_sel != '0) |-> dout == $past(stages[SEL_W'(tap_sel - 1'b1)])); // R1

endmodule

// File: tb/vtap_shift_reg_tb.sv
module vtap_shift_reg_tb;

    localparam int          CLK_P = 100;
    localparam int          DEPTH = 16;
    localparam logic [15:0] INIT  = 16'hA5C3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic       dout;
    logic       dout_dflt;

    int checks = 0;
    int errors = 0;
    bit ref_q[$];

    always #(CLK_P/2) clk = ~clk;

    vtap_shift_reg #(.DEPTH(DEPTH), .INIT_VAL(INIT)) u_dut (
        .clk(clk), .rst(rst), .din(din), .tap_sel(tap_sel), .dout(dout));

    vtap_shift_reg #(.DEPTH(DEPTH)) u_dut_dflt (
        .clk(clk), .rst(rst), .din(din), .tap_sel(tap_sel), .dout(dout_dflt));

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%b expected=%b t=%0t", req, tap_sel, act, exp, $time);
        end
    endtask

    task automatic model_load_init();
        ref_q.delete();
        for (int k = 0; k < DEPTH; k++) ref_q.push_back(INIT[k]);
    endtask

    task automatic model_edge(input bit d, input bit r);
        if (r) model_load_init();
        else begin
            ref_q.push_front(d);
            void'(ref_q.pop_back());
        end
    endtask

    // Drive one cycle, check output before the edge, then advance the model.
    task automatic cycle(input bit d, input logic [3:0] s, input bit r, input string req);
        @(negedge clk);
        din = d; tap_sel = s; rst = r;
        #1;
        chk(dout, ref_q[s], req);
        @(posedge clk);
        model_edge(d, r);
    endtask

    task automatic latency_probe(input logic [3:0] s);
        int cnt;
        for (int i = 0; i < DEPTH; i++) cycle(1'b0, s, 1'b0, "R8 flush");
        cycle(1'b1, s, 1'b0, "R8 push");
        cnt = 1;
        forever begin
            @(negedge clk);
            din = 1'b0;
            #1;
            if (dout === 1'b1 || cnt > DEPTH + 2) break;
            @(posedge clk);
            model_edge(1'b0, 1'b0);
            cnt++;
        end
        checks++;
        if (cnt != int'(s) + 1) begin
            errors++;
            $display("FAIL R8 latency sel=%0d actual=%0d expected=%0d", s, cnt, int'(s) + 1);
        end
        @(posedge clk);
        model_edge(1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_P * 60000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_load_init();
        // R4 / R5: power-up contents, swept before any clock edge.
        for (int s = 0; s < DEPTH; s++) begin
            tap_sel = 4'(s);
            #1;
            chk(dout, INIT[s], "R4 power-up map");
            chk(dout_dflt, 1'b0, "R5 default clear");
        end
        // R6: reset held for two edges with din high.
        cycle(1'b1, 4'd0, 1'b1, "R6 reset");
        cycle(1'b1, 4'd15, 1'b1, "R6 reset");
        for (int s = 0; s < DEPTH; s++) begin
            tap_sel = 4'(s);
            #1;
            chk(dout, INIT[s], "R6 reload ignores din");
            chk(dout_dflt, 1'b0, "R6 default reload");
        end
        // R1 / R2: static lengths with random data.
        for (int i = 0; i < 40; i++) cycle(1'($urandom), 4'd0, 1'b0, "R1 static sel0");
        for (int i = 0; i < 40; i++) cycle(1'($urandom), 4'd7, 1'b0, "R1 static sel7");
        for (int i = 0; i < 40; i++) cycle(1'($urandom), 4'd15, 1'b0, "R2 static sel15");
        // R7: select changes every cycle.
        for (int i = 0; i < 300; i++) cycle(1'($urandom), 4'($urandom), 1'b0, "R7 dynamic");
        // R3: combinational select sweep within one cycle.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            din = 1'($urandom);
            for (int s = 0; s < DEPTH; s++) begin
                tap_sel = 4'(s);
                #1;
                chk(dout, ref_q[s], "R3 comb select");
            end
            @(posedge clk);
            model_edge(din, 1'b0);
        end
        // R8: entry-to-output latency.
        latency_probe(4'd0);
        latency_probe(4'd5);
        latency_probe(4'd15);
        // R6: reset mid-run, then continue dynamically.
        for (int i = 0; i < 20; i++) cycle(1'b1, 4'($urandom), 1'b0, "R2 fill ones");
        cycle(1'b1, 4'd3, 1'b1, "R6 mid reset");
        for (int s = 0; s < DEPTH; s++) begin
            tap_sel = 4'(s);
            #1;
            chk(dout, INIT[s], "R6 mid reload");
        end
        for (int i = 0; i < 100; i++) cycle(1'($urandom), 4'($urandom), 1'b0, "R7 after reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule